// File: doc/BRIEF.md
# Load Data Formatter

This block sits between the data return path of a load pipeline and the register file write port. It receives the raw bytes fetched from memory, right-aligned with byte 0 as the lowest address, and produces the value to be written to a 32-bit register or a 64-bit register pair. Four load kinds are supported: a plain load with sign or zero extension, an expanding load that spreads bytes into halfword lanes, an alignment load that shifts an existing pair and inserts new data at the top, and a predicated load that either delivers the plain result or writes zero when its predicate cancels it.

The result is registered: a request presented with `in_valid` high appears on `out_result` with `out_we` high on the following cycle. A two-state machine tracks the output: `ST_IDLE` (no write pending) and `ST_WRITE` (a formatted result is on the output). The transition `IDLE_TO_WRITE` is taken when `in_valid` is high in `ST_IDLE`. `WRITE_TO_WRITE` is taken when another request arrives in `ST_WRITE`. `WRITE_TO_IDLE` is taken when no request arrives in `ST_WRITE`. `IDLE_HOLD` keeps the machine in `ST_IDLE` when nothing arrives. Address generation and memory timing belong to other blocks.

Top module: `ldf_unit`

## Requirements
- R1: While reset is asserted and on the first clock after its release, `out_we` is 0 and `out_result` is all zeros.
- R2: `out_we` is 1 in exactly the cycle after a cycle with `in_valid` high, and 0 after a cycle with `in_valid` low.
- R3: Kind code 0 (plain), size code 0 (byte) or 1 (halfword), with `in_signed` set: the low 8 or 16 bits of `raw_data` are sign-extended to 64 bits.
- R4: Kind code 0 with `in_signed` clear gives the byte or halfword zero-extended. Size code 2 (word) always zero-extends the low 32 bits, and size code 3 passes all 64 bits unchanged, whatever the value of `in_signed`.
- R5: Kind code 1 (expand) with size code 1: byte i of `raw_data` (i = 0,1) fills halfword i of the result (bits 16i+15:16i), sign- or zero-extended per `in_signed`, and bits 63:32 are zero.
- R6: Kind code 1 with any other size code: bytes 0..3 of `raw_data` fill halfwords 0..3 of the 64-bit result with the same extension rule.
- R7: Kind code 2 (align) with a size code other than 0: the result is `old_pair` shifted right by 16, with bits 15:0 of `raw_data` placed in bits 63:48.
- R8: Kind code 2 with size code 0: the result is `old_pair` shifted right by 8, with bits 7:0 of `raw_data` placed in bits 63:56.
- R9: Kind code 3 (predicated): the tested bit is `pred_new` when `pred_use_new` is 1, otherwise `pred_old`, and it is XORed with `pred_negate`. A 1 gives the same result as kind code 0 with the same size and sign.
- R10: Kind code 3 with a tested bit of 0 (cancelled) writes an all-zero result and still raises `out_we`.
- R11: After a cycle with `in_valid` low, `out_result` keeps its previous value regardless of the other inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A load request is present this cycle |
| in_kind | input | 2 | 0 plain, 1 expand, 2 align, 3 predicated |
| in_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| in_signed | input | 1 | 1 selects sign extension |
| pred_old | input | 1 | Lowest bit of the predicate as it was before the packet |
| pred_new | input | 1 | Lowest bit of the predicate produced within the packet |
| pred_use_new | input | 1 | 1 tests `pred_new`, 0 tests `pred_old` |
| pred_negate | input | 1 | 1 inverts the tested predicate bit |
| raw_data | input | PAIR_W | Fetched data, right-aligned, little-endian |
| old_pair | input | PAIR_W | Current destination pair, used by align loads |
| out_we | output | 1 | Write enable for the destination |
| out_result | output | PAIR_W | Value to write |

## Verification
The bench builds the unit with its defaults: 8-bit lanes and a 64-bit pair. With these values each size code maps to a real width, and the expand and align kinds cross the 32-bit boundary between the register halves. Random raw data with the top bit of each lane set reaches every sign-extension path. Back-to-back requests and idle gaps with random inputs exercise every transition of the output machine. All predicate combinations are driven for every size, so cancellation and selection are covered against the plain path.

// File: rtl/ldf_pkg.sv
package ldf_pkg;

    typedef enum logic [1:0] {
        LK_PLAIN  = 2'd0,
        LK_EXPAND = 2'd1,
        LK_ALIGN  = 2'd2,
        LK_PRED   = 2'd3
    } ld_kind_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_WRITE = 1'b1
    } out_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;
    localparam logic [1:0] SZ_DBL  = 2'd3;

endpackage

// File: rtl/ldf_extend.sv
// Plain load formatting: pick 1, 2, 4 or 8 bytes and extend to the pair width.
module ldf_extend #(
    parameter int LANE_W = 8,
    parameter int PAIR_W = 64
) (
    input  logic [PAIR_W-1:0] raw,
    input  logic [1:0]        size,
    input  logic              sign_en,
    output logic [PAIR_W-1:0] ext
);
    localparam int N_SIZES = 4;

    logic [PAIR_W-1:0] cand [N_SIZES];

    for (genvar g = 0; g < N_SIZES; g++) begin : g_size
        localparam int W = LANE_W << g;
        if (W >= PAIR_W) begin : g_full
            assign cand[g] = raw;
        end else if (g < 2) begin : g_signable
            assign cand[g] = {{(PAIR_W - W){sign_en & raw[W-1]}}, raw[W-1:0]};
        end else begin : g_zero
            assign cand[g] = {{(PAIR_W - W){1'b0}}, raw[W-1:0]};
        end
    end

    always_comb begin
        ext = cand[size];
    end
endmodule

// File: rtl/ldf_expand.sv
// Expanding load: each fetched byte becomes one halfword lane.
module ldf_expand #(
    parameter int LANE_W = 8,
    parameter int PAIR_W = 64
) (
    input  logic [PAIR_W/2-1:0] raw_lo,
    input  logic                wide,
    input  logic                sign_en,
    output logic [PAIR_W-1:0]   expd
);
    localparam int HALF_W   = 2 * LANE_W;
    localparam int N_LANES  = PAIR_W / HALF_W;
    localparam int N_NARROW = N_LANES / 2;

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        logic [LANE_W-1:0] byte_in;
        logic              fill;
        logic              keep;
        assign byte_in = raw_lo[i*LANE_W +: LANE_W];
        assign fill    = sign_en & byte_in[LANE_W-1];
        assign keep    = wide | (i < N_NARROW);
        assign expd[i*HALF_W +: HALF_W] = keep ? {{LANE_W{fill}}, byte_in}
                                               : {HALF_W{1'b0}};
    end
endmodule

// File: rtl/ldf_align.sv
// Alignment load: shift the old pair down and insert fresh data at the top.
module ldf_align #(
    parameter int LANE_W = 8,
    parameter int PAIR_W = 64
) (
    input  logic [2*LANE_W-1:0] raw_lo,
    input  logic [PAIR_W-1:0]   old_pair,
    input  logic                half_mode,
    output logic [PAIR_W-1:0]   aligned
);
    localparam int HALF_W = 2 * LANE_W;

    logic [PAIR_W-1:0] ins_byte;
    logic [PAIR_W-1:0] ins_half;

    always_comb begin
        ins_byte = {{(PAIR_W - LANE_W){1'b0}}, raw_lo[LANE_W-1:0]} << (PAIR_W - LANE_W);
        ins_half = {{(PAIR_W - HALF_W){1'b0}}, raw_lo} << (PAIR_W - HALF_W);
        if (half_mode) begin
            aligned = (old_pair >> HALF_W) | ins_half;
        end else begin
            aligned = (old_pair >> LANE_W) | ins_byte;
        end
    end
endmodule

// File: rtl/ldf_predicate.sv
// Predicate test for conditional loads.
module ldf_predicate (
    input  logic pred_old,
    input  logic pred_new,
    input  logic use_new,
    input  logic negate,
    output logic pass
);
    logic tested;

    always_comb begin
        tested = use_new ? pred_new : pred_old;
        pass   = tested ^ negate;
    end
endmodule

// File: rtl/ldf_unit.sv
module ldf_unit #(
    parameter int LANE_W = 8,
    parameter int PAIR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_kind,
    input  logic [1:0]        in_size,
    input  logic              in_signed,
    input  logic              pred_old,
    input  logic              pred_new,
    input  logic              pred_use_new,
    input  logic              pred_negate,
    input  logic [PAIR_W-1:0] raw_data,
    input  logic [PAIR_W-1:0] old_pair,
    output logic              out_we,
    output logic [PAIR_W-1:0] out_result
);
    import ldf_pkg::*;

    localparam int HALF_W = 2 * LANE_W;

    ld_kind_e          kind;
    out_state_e        state_q;
    out_state_e        state_d;
    logic [PAIR_W-1:0] plain_val;
    logic [PAIR_W-1:0] expand_val;
    logic [PAIR_W-1:0] align_val;
    logic              pred_pass;
    logic [PAIR_W-1:0] next_result;
    logic [PAIR_W-1:0] result_q;

    assign kind = ld_kind_e'(in_kind);

    ldf_extend #(.LANE_W(LANE_W), .PAIR_W(PAIR_W)) u_extend (
        .raw     (raw_data),
        .size    (in_size),
        .sign_en (in_signed),
        .ext     (plain_val)
    );

    ldf_expand #(.LANE_W(LANE_W), .PAIR_W(PAIR_W)) u_expand (
        .raw_lo  (raw_data[PAIR_W/2-1:0]),
        .wide    (in_size != SZ_HALF),
        .sign_en (in_signed),
        .expd    (expand_val)
    );

    ldf_align #(.LANE_W(LANE_W), .PAIR_W(PAIR_W)) u_align (
        .raw_lo    (raw_data[HALF_W-1:0]),
        .old_pair  (old_pair),
        .half_mode (in_size != SZ_BYTE),
        .aligned   (align_val)
    );

    ldf_predicate u_pred (
        .pred_old (pred_old),
        .pred_new (pred_new),
        .use_new  (pred_use_new),
        .negate   (pred_negate),
        .pass     (pred_pass)
    );

    always_comb begin
        unique case (kind)
            LK_PLAIN:  next_result = plain_val;
            LK_EXPAND: next_result = expand_val;
            LK_ALIGN:  next_result = align_val;
            LK_PRED:   next_result = pred_pass ? plain_val : '0;
            default:   next_result = '0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = in_valid ? ST_WRITE : ST_IDLE;
            ST_WRITE: state_d = in_valid ? ST_WRITE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (in_valid) begin
            result_q <= next_result;
        end
    end

    assign out_we     = (state_q == ST_WRITE);
    assign out_result = result_q;
endmodule

// File: rtl/ldf_unit_chk.sv
module ldf_unit_chk #(
    parameter int LANE_W = 8,
    parameter int PAIR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        in_kind,
    input logic [1:0]        in_size,
    input logic              pred_old,
    input logic              pred_new,
    input logic              pred_use_new,
    input logic              pred_negate,
    input logic [PAIR_W-1:0] old_pair,
    input logic              out_we,
    input logic [PAIR_W-1:0] out_result
);
    localparam int HALF_W = 2 * LANE_W;

    logic cancel_req;
    assign cancel_req = in_valid && (in_kind == 2'd3) &&
                        (((pred_use_new ? pred_new : pred_old) ^ pred_negate) == 1'b0);

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_we && out_result == '0)); // R1

    AST_WE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_we); // R2

    AST_NO_WE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_we); // R2

    AST_EXPAND_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 2'd1 && in_size == 2'd1) |=> (out_result[PAIR_W-1:PAIR_W/2] == '0)); // R5

    AST_ALIGN_HALF_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 2'd2 && in_size != 2'd0)
        |=> (out_result[PAIR_W-HALF_W-1:0] == $past(old_pair[PAIR_W-1:HALF_W]))); // R7

    AST_ALIGN_BYTE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 2'd2 && in_size == 2'd0)
        |=> (out_result[PAIR_W-LANE_W-1:0] == $past(old_pair[PAIR_W-1:LANE_W]))); // R8

    AST_CANCEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_req |=> (out_we && out_result == '0)); // R10

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result)); // R11
endmodule

bind ldf_unit ldf_unit_chk #(.LANE_W(LANE_W), .PAIR_W(PAIR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_kind      (in_kind),
    .in_size      (in_size),
    .pred_old     (pred_old),
    .pred_new     (pred_new),
    .pred_use_new (pred_use_new),
    .pred_negate  (pred_negate),
    .old_pair     (old_pair),
    .out_we       (out_we),
    .out_result   (out_result)
);

// File: tb/ldf_unit_tb.sv
module ldf_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYC = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_kind = '0;
    logic [1:0]  in_size = '0;
    logic        in_signed = 1'b0;
    logic        pred_old = 1'b0;
    logic        pred_new = 1'b0;
    logic        pred_use_new = 1'b0;
    logic        pred_negate = 1'b0;
    logic [63:0] raw_data = '0;
    logic [63:0] old_pair = '0;
    logic        out_we;
    logic [63:0] out_result;

    int    n_vec = 0;
    int    n_bad = 0;
    logic        exp_we = 1'b0;
    logic [63:0] exp_res = '0;
    string       exp_tag = "R1";
    bit          finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ldf_unit u_dut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_kind (in_kind),
        .in_size (in_size), .in_signed (in_signed), .pred_old (pred_old),
        .pred_new (pred_new), .pred_use_new (pred_use_new), .pred_negate (pred_negate),
        .raw_data (raw_data), .old_pair (old_pair), .out_we (out_we), .out_result (out_result)
    );

    function automatic logic [63:0] plain_model(logic [1:0] sz, logic sg, logic [63:0] r);
        longint v;
        case (sz)
            2'd0: v = sg ? longint'($signed(r[7:0]))  : longint'(r[7:0]);
            2'd1: v = sg ? longint'($signed(r[15:0])) : longint'(r[15:0]);
            2'd2: v = longint'(r[31:0]);
            default: v = longint'(r);
        endcase
        return 64'(v);
    endfunction

    function automatic logic [63:0] model(logic [1:0] k, logic [1:0] sz, logic sg,
                                          logic po, logic pn, logic un, logic ng,
                                          logic [63:0] r, logic [63:0] old);
        logic [63:0] v = '0;
        int lanes;
        logic t;
        case (k)
            2'd0: v = plain_model(sz, sg, r);
            2'd1: begin
                lanes = (sz == 2'd1) ? 2 : 4;
                for (int i = 0; i < lanes; i++) begin
                    int b = int'(r[8*i +: 8]);
                    if (sg && b > 127) b = b - 256;
                    v[16*i +: 16] = 16'(b);
                end
            end
            2'd2: v = (sz == 2'd0) ? {r[7:0], old[63:8]} : {r[15:0], old[63:16]};
            default: begin
                t = (un ? pn : po) ^ ng;
                v = t ? plain_model(sz, sg, r) : 64'd0;
            end
        endcase
        return v;
    endfunction

    function automatic string tag_of(logic [1:0] k, logic [1:0] sz, logic sg,
                                     logic po, logic pn, logic un, logic ng);
        case (k)
            2'd0: return (sg && sz < 2) ? "R3" : "R4";
            2'd1: return (sz == 2'd1) ? "R5" : "R6";
            2'd2: return (sz == 2'd0) ? "R8" : "R7";
            default: return (((un ? pn : po) ^ ng) != 1'b0) ? "R9" : "R10";
        endcase
    endfunction

    task automatic compare();
        n_vec++;
        if (out_we !== exp_we) begin
            n_bad++;
            $display("FAIL R2 out_we actual=%0b expected=%0b", out_we, exp_we);
        end
        n_vec++;
        if (out_result !== exp_res) begin
            n_bad++;
            $display("FAIL %s out_result actual=%h expected=%h", exp_tag, out_result, exp_res);
        end
    endtask

    task automatic apply(logic v, logic [1:0] k, logic [1:0] sz, logic sg,
                         logic po, logic pn, logic un, logic ng,
                         logic [63:0] r, logic [63:0] old);
        @(negedge clk);
        compare();
        in_valid = v; in_kind = k; in_size = sz; in_signed = sg;
        pred_old = po; pred_new = pn; pred_use_new = un; pred_negate = ng;
        raw_data = r; old_pair = old;
        exp_we = v;
        if (v) begin
            exp_res = model(k, sz, sg, po, pn, un, ng, r, old);
            exp_tag = tag_of(k, sz, sg, po, pn, un, ng);
        end else begin
            exp_tag = "R11";
        end
    endtask

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        n_vec++;
        if (out_we !== 1'b0 || out_result !== 64'd0) begin
            n_bad++;
            $display("FAIL R1 reset actual=%0b/%h expected=0/0", out_we, out_result);
        end
        rst_n = 1'b1;
        // R1: first clock after release, compared by the next apply
        exp_tag = "R1";
        apply(0, 0, 0, 0, 0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, '1);
        // R3 / R4 plain loads
        apply(1, 0, 0, 1, 0, 0, 0, 0, 64'h1122_3344_5566_7780, '0);
        apply(1, 0, 1, 1, 0, 0, 0, 0, 64'h1122_3344_5566_8001, '0);
        apply(1, 0, 0, 0, 0, 0, 0, 0, 64'h1122_3344_5566_77F0, '0);
        apply(1, 0, 2, 1, 0, 0, 0, 0, 64'h1122_3344_8566_7788, '0);
        apply(1, 0, 3, 1, 0, 0, 0, 0, 64'h8122_3344_5566_7788, '0);
        // R5 / R6 expanding loads
        apply(1, 1, 1, 1, 0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_7F80, '0);
        apply(1, 1, 1, 0, 0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_7F80, '0);
        apply(1, 1, 2, 1, 0, 0, 0, 0, 64'h0000_0000_80FF_017F, '0);
        // R7 / R8 alignment, streamed back to back
        apply(1, 2, 1, 0, 0, 0, 0, 0, 64'h0000_0000_0000_BEEF, 64'h0123_4567_89AB_CDEF);
        apply(1, 2, 0, 0, 0, 0, 0, 0, 64'h0000_0000_0000_00A5, 64'h0123_4567_89AB_CDEF);
        // R9 / R10 predicated loads
        apply(1, 3, 0, 1, 1, 0, 0, 0, 64'h0000_0000_0000_0090, '0);
        apply(1, 3, 0, 1, 0, 1, 0, 0, 64'h0000_0000_0000_0090, '0);
        apply(1, 3, 1, 0, 0, 1, 1, 0, 64'h0000_0000_0000_9090, '0);
        apply(1, 3, 2, 0, 1, 1, 1, 1, 64'h1234_5678_9ABC_DEF0, '0);
        apply(1, 3, 2, 0, 0, 0, 0, 1, 64'h1234_5678_9ABC_DEF0, '0);
        // R11: idle cycles with changing inputs
        apply(0, 1, 3, 1, 1, 1, 1, 1, 64'hDEAD_BEEF_DEAD_BEEF, '1);
        apply(0, 3, 0, 0, 0, 0, 0, 1, 64'h0, '0);
        // random mix
        for (int n = 0; n < 3000; n++) begin
            apply(($urandom_range(0, 3) != 0), 2'($urandom), 2'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  {$urandom, $urandom}, {$urandom, $urandom});
        end
        apply(0, 0, 0, 0, 0, 0, 0, 0, '0, '0);
        apply(0, 0, 0, 0, 0, 0, 0, 0, '0, '0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule